// File: doc/BRIEF.md
# Grouped-Timebase Eight-Channel PWM Generator

This block drives eight pulse-width-modulated outputs from four shared timebases. Each timebase (a "group") takes one of two external enable ticks, a fast one or a slow one, and divides it by a 16-bit prescaler. The divided rate advances a cycle counter that runs from zero to a programmable cycle time N and then wraps. Each channel is bound to one group through a 2-bit select field. It compares that group's cycle counter against its own 8-bit duty value, so channels on the same group share a period but can have different high times.

Software programs the block through a byte-wide write port with a combinational read-back. A global enable starts all counters. A per-channel pin-control byte either passes the PWM waveform or parks the output at a fixed level. One group carries a 2-bit extension of its cycle time, which makes it a 10-bit timebase. Duty, cycle time and prescaler writes go to shadow registers. The running copies are reloaded only when the owning group's counter wraps, so a period is never cut short or stretched.

Top module: `pwm_grouped`

## Requirements
- R1: Every writable register reads back the last value written. The group select for channel c is the 2-bit field at bit (c mod 4)*2. Channels 0 to 3 use address 0x08 and channels 4 to 7 use address 0x09. Duty registers sit at 0x00+c and pin-control bytes at 0x20+c.
- R2: Group g's prescaler P is {byte at 0x12+4g, byte at 0x11+4g}. The cycle counter advances once every P+1 source ticks.
- R3: Group g's cycle time N is at 0x10+4g. The cycle counter never exceeds N and the period is N+1 prescaled steps, which is (N+1)*(P+1) source ticks.
- R4: Bit g of the source register at 0x0A selects group g's source. 1 selects the fast tick and 0 selects the slow tick.
- R5: A channel in PWM mode is high while the counter is below its duty value D. D=0 gives a constant low. A nonzero D that is at or above N gives a constant high.
- R6: Bit 1 of address 0x0B is the global counter enable. While it is clear, all counters are held at zero and every PWM-mode output is low.
- R7: A pin-control byte of 0x00 passes the PWM waveform. With bit 7 set, the output is held at the level of bit 2.
- R8: The group-1 extension at 0x17 resets to 3. Group 1's cycle time is {ext[1:0], N}. Extension writes to any other group (for example 0x1B) are ignored and read back 0.
- R9: New duty, cycle-time and prescaler values take effect only when the owning group's counter wraps (or while counting is disabled). A duty write in mid-period leaves that period's high time unchanged.
- R10: After reset every register reads 0 except the group-1 extension, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | Enable pulse of the fast source |
| slow_tick | input | 1 | Enable pulse of the slow source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pwm_o | output | NCH | Registered channel outputs |

## Verification
The bench builds the block with its default parameters: eight channels, four groups, a 2-bit extension on group 1 and a reset extension of 3. With these values, all four groups run at once with mixed fast and slow sources, and both select registers carry non-trivial fields. The 10-bit extended period (259 steps) and a prescaler whose high byte is set (P=256) both fit within a short run. The fast tick is held high and the slow tick pulses every fourth clock, so the expected high time and period in clocks follow directly from the formula.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  localparam int BYTE_W = 8;
  localparam int PS_W   = 16;

  localparam logic [5:0] A_GSEL_LO = 6'h08;
  localparam logic [5:0] A_GSEL_HI = 6'h09;
  localparam logic [5:0] A_SRC     = 6'h0A;
  localparam logic [5:0] A_EN      = 6'h0B;

  localparam int EN_BIT       = 1;
  localparam int PIN_HOLD_BIT = 7;
  localparam int PIN_LVL_BIT  = 2;

  // Bit position of channel ch's select field inside its select byte.
  function automatic int sel_lsb(int ch, int sel_w);
    return (ch % (BYTE_W / sel_w)) * sel_w;
  endfunction

  // Which select byte holds channel ch.
  function automatic int sel_byte(int ch, int sel_w);
    return ch / (BYTE_W / sel_w);
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_grp_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int NGRP    = 4,
  parameter int EW      = 2,
  parameter int EXT_GRP = 1,
  parameter int EXT_RST = 3,
  localparam int SEL_W  = $clog2(NGRP),
  localparam int CW     = BYTE_W + EW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [5:0]                     addr,
  input  logic [7:0]                     wdata,
  output logic [7:0]                     rdata,
  output logic [NCH-1:0][BYTE_W-1:0]     duty_sh,
  output logic [NCH-1:0][SEL_W-1:0]      gsel,
  output logic [NGRP-1:0]                src_fast,
  output logic                           cnt_en,
  output logic [NGRP-1:0][CW-1:0]        ct_sh,
  output logic [NGRP-1:0][PS_W-1:0]      ps_sh,
  output logic [NCH-1:0][BYTE_W-1:0]     pinctl
);
  logic [NCH-1:0][7:0]  duty_q;
  logic [1:0][7:0]      sel_q;
  logic [NGRP-1:0]      src_q;
  logic                 en_q;
  logic [NGRP-1:0][7:0] ct_q;
  logic [NGRP-1:0][15:0] ps_q;
  logic [EW-1:0]        ext_q;
  logic [NCH-1:0][7:0]  pin_q;

  logic [2:0] ch_idx;
  logic [1:0] g_idx;
  logic       hit_duty, hit_grp, hit_pin;

  assign ch_idx   = addr[2:0];
  assign g_idx    = addr[3:2];
  assign hit_duty = (addr[5:3] == 3'b000);
  assign hit_grp  = (addr[5:4] == 2'b01);
  assign hit_pin  = (addr[5:3] == 3'b100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      sel_q  <= '0;
      src_q  <= '0;
      en_q   <= 1'b0;
      ct_q   <= '0;
      ps_q   <= '0;
      ext_q  <= EW'(EXT_RST);
      pin_q  <= '0;
    end else if (wr_en) begin
      if (hit_duty) duty_q[ch_idx] <= wdata;
      if (hit_pin)  pin_q[ch_idx]  <= wdata;
      if (addr == A_GSEL_LO) sel_q[0] <= wdata;
      if (addr == A_GSEL_HI) sel_q[1] <= wdata;
      if (addr == A_SRC)     src_q    <= wdata[NGRP-1:0];
      if (addr == A_EN)      en_q     <= wdata[EN_BIT];
      if (hit_grp) begin
        case (addr[1:0])
          2'd0: ct_q[g_idx]        <= wdata;
          2'd1: ps_q[g_idx][7:0]   <= wdata;
          2'd2: ps_q[g_idx][15:8]  <= wdata;
          default: if (int'(g_idx) == EXT_GRP) ext_q <= wdata[EW-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_duty)               rdata = duty_q[ch_idx];
    else if (hit_pin)           rdata = pin_q[ch_idx];
    else if (addr == A_GSEL_LO) rdata = sel_q[0];
    else if (addr == A_GSEL_HI) rdata = sel_q[1];
    else if (addr == A_SRC)     rdata = {{(8-NGRP){1'b0}}, src_q};
    else if (addr == A_EN)      rdata = {6'b0, en_q, 1'b0};
    else if (hit_grp) begin
      case (addr[1:0])
        2'd0:    rdata = ct_q[g_idx];
        2'd1:    rdata = ps_q[g_idx][7:0];
        2'd2:    rdata = ps_q[g_idx][15:8];
        default: rdata = (int'(g_idx) == EXT_GRP) ? 8'(ext_q) : 8'h00;
      endcase
    end
  end

  assign duty_sh  = duty_q;
  assign pinctl   = pin_q;
  assign src_fast = src_q;
  assign cnt_en   = en_q;
  assign ps_sh    = ps_q;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign gsel[c] = sel_q[sel_byte(c, SEL_W)][sel_lsb(c, SEL_W) +: SEL_W];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_ct
    if (g == EXT_GRP) begin : g_ext
      assign ct_sh[g] = {ext_q, ct_q[g]};
    end else begin : g_plain
      assign ct_sh[g] = {{EW{1'b0}}, ct_q[g]};
    end
  end

  // R8: non-extended groups never present upper cycle-time bits
  p_ext_only_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_sh[(EXT_GRP + 1) % NGRP][CW-1:BYTE_W] == '0));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_grp_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            fast_tick,
  input  logic            slow_tick,
  input  logic            use_fast,
  input  logic [CW-1:0]   ct_sh,
  input  logic [PS_W-1:0] ps_sh,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   ct_o,
  output logic            load_o,
  output logic            wrap_o
);
  logic [PS_W-1:0] pc_q, ps_act;
  logic [CW-1:0]   cnt_q, ct_act;
  logic            tick, step, wrap;

  assign tick   = use_fast ? fast_tick : slow_tick;
  assign step   = cnt_en && tick && (pc_q == ps_act);
  assign wrap   = step && (cnt_q == ct_act);
  assign load_o = wrap || !cnt_en;
  assign wrap_o = wrap;
  assign cnt_o  = cnt_q;
  assign ct_o   = ct_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      ps_act <= '0;
      ct_act <= '0;
    end else if (!cnt_en) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      ps_act <= ps_sh;
      ct_act <= ct_sh;
    end else if (tick) begin
      if (step) begin
        pc_q <= '0;
        if (wrap) begin
          cnt_q  <= '0;
          ps_act <= ps_sh;
          ct_act <= ct_sh;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= ps_act);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ct_act);
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (cnt_q == '0) && (pc_q == '0));
  p_latch_only_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> $stable(ct_act) && $stable(ps_act));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_grp_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [BYTE_W-1:0] duty_sh,
  input  logic [BYTE_W-1:0] pinctl,
  input  logic [CW-1:0]     grp_cnt,
  input  logic [CW-1:0]     grp_ct,
  input  logic              grp_load,
  output logic              pwm_o
);
  logic [BYTE_W-1:0] duty_act;
  logic              raw, pwm_q;

  // Level of the waveform at a given counter position.
  function automatic logic pwm_level(logic [CW-1:0] cnt, logic [CW-1:0] ct,
                                     logic [BYTE_W-1:0] duty);
    logic [CW-1:0] d;
    d = CW'(duty);
    if (duty == '0) return 1'b0;
    if (d >= ct)    return 1'b1;
    return cnt < d;
  endfunction

  assign raw = cnt_en && pwm_level(grp_cnt, grp_ct, duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (grp_load) duty_act <= duty_sh;
      pwm_q <= pinctl[PIN_HOLD_BIT] ? pinctl[PIN_LVL_BIT] : raw;
    end
  end

  assign pwm_o = pwm_q;

  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pinctl[PIN_HOLD_BIT] && duty_act == '0) |=> !pwm_o);
  p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !pinctl[PIN_HOLD_BIT] && duty_act != '0 && CW'(duty_act) >= grp_ct)
      |=> pwm_o);
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !pinctl[PIN_HOLD_BIT]) |=> !pwm_o);
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pinctl[PIN_HOLD_BIT] |=> (pwm_o == $past(pinctl[PIN_LVL_BIT])));
  p_duty_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_load |=> $stable(duty_act));
endmodule

// File: rtl/pwm_grouped.sv
module pwm_grouped
  import pwm_grp_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int NGRP    = 4,
  parameter int EW      = 2,
  parameter int EXT_GRP = 1,
  parameter int EXT_RST = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fast_tick,
  input  logic           slow_tick,
  input  logic           wr_en,
  input  logic [5:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic [NCH-1:0] pwm_o
);
  localparam int SEL_W = $clog2(NGRP);
  localparam int CW    = BYTE_W + EW;

  logic [NCH-1:0][BYTE_W-1:0] duty_sh, pinctl;
  logic [NCH-1:0][SEL_W-1:0]  gsel;
  logic [NGRP-1:0]            src_fast;
  logic                       cnt_en;
  logic [NGRP-1:0][CW-1:0]    ct_sh, grp_cnt, grp_ct;
  logic [NGRP-1:0][PS_W-1:0]  ps_sh;
  logic [NGRP-1:0]            grp_load, grp_wrap;

  pwm_regfile #(
    .NCH(NCH), .NGRP(NGRP), .EW(EW), .EXT_GRP(EXT_GRP), .EXT_RST(EXT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .duty_sh(duty_sh), .gsel(gsel), .src_fast(src_fast),
    .cnt_en(cnt_en), .ct_sh(ct_sh), .ps_sh(ps_sh), .pinctl(pinctl)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pwm_timebase #(.CW(CW)) u_tb (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .fast_tick(fast_tick), .slow_tick(slow_tick), .use_fast(src_fast[g]),
      .ct_sh(ct_sh[g]), .ps_sh(ps_sh[g]),
      .cnt_o(grp_cnt[g]), .ct_o(grp_ct[g]),
      .load_o(grp_load[g]), .wrap_o(grp_wrap[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .duty_sh(duty_sh[c]), .pinctl(pinctl[c]),
      .grp_cnt(grp_cnt[gsel[c]]), .grp_ct(grp_ct[gsel[c]]),
      .grp_load(grp_load[gsel[c]]), .pwm_o(pwm_o[c])
    );
  end

  // R6: no group wraps while the global enable is clear
  p_no_wrap_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (grp_wrap == '0));
  // R3: a group wraps only from its top count
  p_wrap_at_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grp_wrap[0] |-> (grp_cnt[0] == grp_ct[0]));
endmodule

// File: tb/test_pwm_grouped.sv
module test_pwm_grouped;
  localparam int NCH = 8;
  localparam int SLOW_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_tick = 1'b1;
  logic slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [NCH-1:0] pwm_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int    ch;
    int    hi;    // expected high clocks, or the constant level when per==0
    int    per;   // expected period in clocks; 0 means constant level
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pwm_grouped i_pwm_grouped (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  initial begin : slow_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % SLOW_DIV;
      slow_tick = (k == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int period_clk(int n, int p, int div);
    return (n + 1) * (p + 1) * div;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic push(input int ch, input int hi, input int per, input string tag);
    exp_t e;
    e.ch = ch; e.hi = hi; e.per = per; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measures the channel named by the head item, then retires it.
  initial begin : monitor
    forever begin
      wait (q.size() > 0);
      begin
        exp_t e;
        int hi, lo;
        bit steady;
        e = q[0];
        if (e.per == 0) begin
          steady = 1'b1;
          for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pwm_o[e.ch] != e.hi[0]) steady = 1'b0;
          end
          chk(steady, e.tag, pwm_o[e.ch], e.hi);
        end else begin
          hi = 0; lo = 0;
          do @(negedge clk); while (pwm_o[e.ch] != 1'b0);
          do @(negedge clk); while (pwm_o[e.ch] != 1'b1);
          while (pwm_o[e.ch]) begin hi++; @(negedge clk); end
          while (!pwm_o[e.ch]) begin lo++; @(negedge clk); end
          chk(hi == e.hi, {e.tag, " high"}, hi, e.hi);
          chk(hi + lo == e.per, {e.tag, " period"}, hi + lo, e.per);
        end
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R10 / R8 reset state
    chk(pwm_o == '0, "R10 outputs low after reset", pwm_o, 0);
    rd_chk(6'h17, 8'h03, "R8 extension reset value");
    rd_chk(6'h0B, 8'h00, "R10 enable clear after reset");
    rd_chk(6'h03, 8'h00, "R10 duty clear after reset");

    // group 0: fast, N=9, P=0 | group 1: fast, ext=0, N=7
    // group 2: slow, N=4, P=1 | group 3: fast, N=19, P=2
    wr(6'h10, 8'd9);
    wr(6'h17, 8'd0);
    wr(6'h14, 8'd7);
    wr(6'h18, 8'd4);
    wr(6'h19, 8'd1);
    wr(6'h1C, 8'd19);
    wr(6'h1D, 8'd2);
    wr(6'h1B, 8'h03);          // ignored: group 2 has no extension
    wr(6'h0A, 8'b1011);
    wr(6'h08, 8'h30);          // ch2 -> group 3
    wr(6'h09, 8'h48);          // ch5 -> group 2, ch7 -> group 1
    wr(6'h00, 8'd4);
    wr(6'h01, 8'd7);
    wr(6'h02, 8'd5);
    wr(6'h05, 8'd2);
    wr(6'h07, 8'd3);

    rd_chk(6'h1B, 8'h00, "R8 extension write to group 2 ignored");
    rd_chk(6'h09, 8'h48, "R1 select byte for channels 4-7");
    rd_chk(6'h00, 8'd4, "R1 duty read-back");
    rd_chk(6'h19, 8'd1, "R1 prescaler low byte read-back");

    wr(6'h0B, 8'h02);          // R6 enable
    idle(100);

    push(0, 4, period_clk(9, 0, 1), "R5 ch0 group0 duty 4");
    push(1, 7, period_clk(9, 0, 1), "R3 ch1 group0 duty 7");
    push(5, 2 * 2 * SLOW_DIV, period_clk(4, 1, SLOW_DIV), "R4 ch5 slow group2");
    push(2, 5 * 3, period_clk(19, 2, 1), "R2 ch2 group3 prescaled");
    push(7, 3, period_clk(7, 0, 1), "R8 ch7 group1 extension cleared");
    push(3, 0, 0, "R5 ch3 duty zero constant low");

    wr(6'h01, 8'd9);
    idle(30);
    push(1, 1, 0, "R5 ch1 duty equal N constant high");
    wr(6'h01, 8'd200);
    idle(30);
    push(1, 1, 0, "R5 ch1 duty above N constant high");

    // R8 10-bit cycle time on group 1: N = {1, 2} = 258
    wr(6'h17, 8'd1);
    wr(6'h14, 8'd2);
    wr(6'h07, 8'd100);
    idle(300);
    push(7, 100, period_clk(258, 0, 1), "R8 ch7 extended cycle time");

    // R9 duty written mid-period keeps the running period's high time
    n = 0;
    do @(negedge clk); while (pwm_o[2] != 1'b0);
    do @(negedge clk); while (pwm_o[2] != 1'b1);
    n = 1;
    wr_en = 1'b1; addr = 6'h02; wdata = 8'd1;
    @(negedge clk);
    wr_en = 1'b0;
    if (pwm_o[2]) n++;
    while (pwm_o[2]) begin
      @(negedge clk);
      if (pwm_o[2]) n++;
    end
    chk(n == 15, "R9 mid-period duty write deferred", n, 15);
    push(2, 3, period_clk(19, 2, 1), "R9 new duty after wrap");

    // R7 pin hold
    wr(6'h20, 8'h84);
    idle(3);
    push(0, 1, 0, "R7 hold high via bit 2");
    wr(6'h20, 8'h82);
    idle(3);
    push(0, 0, 0, "R7 hold low");
    wr(6'h20, 8'h00);
    idle(30);
    push(0, 4, period_clk(9, 0, 1), "R7 back to PWM");

    // R2 prescaler high byte: P = 256
    wr(6'h12, 8'h01);
    idle(30);
    push(0, 4 * 257, period_clk(9, 256, 1), "R2 prescaler high byte");

    // R6 disable
    wr(6'h0B, 8'h00);
    idle(3);
    chk(pwm_o == '0, "R6 outputs low when disabled", pwm_o, 0);
    push(1, 0, 0, "R6 ch1 stays low when disabled");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule